// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

The block guards a processor against runaway code. A prescaler divides the input clock by 2^PS_W (2^13 by default) and every prescaler period advances a 4-bit counter. Software must write the control port at intervals shorter than the chosen timeout to restart the count. If it fails to, the block drives an active-low reset for a fixed number of clocks and then starts a fresh period.

The control port is 4 bits wide and is written through one strobe. Writing 0 to bit 3 restarts the watchdog; the bit is not stored and always reads as 1. Bit 0 selects the timeout: 0 gives 3 prescaler periods, 1 gives 7. Bits 2 and 1 read as 0. A write of 0001 therefore selects the long timeout and restarts the count in one step. An enable input stands for a build-time option: when it is low the block holds its state cleared and its output high. A STOP input freezes the count.

Top module: `wdt_timer`

## Requirements
- R1: After reset the output wdt_rst_no is 1, the timeout select is 0, and rd_data_o reads 4'b1000.
- R2: With select 0, wdt_rst_no goes low 3*2^PS_W clock edges after the edge that took a clearing write.
- R3: With select 1, wdt_rst_no goes low 7*2^PS_W edges after the clearing write; a single write of 4'b0001 both selects this timeout and clears.
- R4: A timeout holds wdt_rst_no low for exactly PULSE_LEN (4) cycles; then prescaler and counter restart from zero, so the next timeout comes a full period after the output returns high.
- R5: A write with bit 3 equal to 0 clears both counter and prescaler, and wins over a timeout due on the same edge.
- R6: A write with bit 3 equal to 1 does not clear or delay the running count.
- R7: rd_data_o always reads bit 3 as 1, bits 2 and 1 as 0, and bit 0 as the last written select value.
- R8: While stop_i is high the prescaler and counter hold; counting resumes where it stopped when stop_i falls.
- R9: While wdt_en_i is low wdt_rst_no stays 1 and the count is held at zero; on enable a full period starts.
- R10: A new select value applies from its write edge: if the counter already meets the new threshold, the timeout fires at the next prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wdt_en_i | input | 1 | Watchdog present/enabled (build-time option) |
| stop_i | input | 1 | STOP mode, freezes counting |
| wr_en_i | input | 1 | Control port write strobe |
| wr_data_i | input | 4 | Control port write data |
| rd_data_o | output | 4 | Control port read value |
| wdt_rst_no | output | 1 | Active-low timeout reset |

## Verification
A wrong prescaler or counter value shows only as a timeout edge that arrives early or late, so every scenario measures the exact edge count from a write to the falling output, and then the low width and the gap to the next timeout. A stuck select or a lost clear shows the same way, one or more prescaler periods off, within at most 7*2^PS_W cycles. A broken read path appears at once on rd_data_o after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W  = 4;
  localparam int CLR_BIT = 3;  // write 0 to clear, reads 1
  localparam int SEL_BIT = 0;  // timeout select

  typedef enum logic {
    SEL_SHORT = 1'b0,
    SEL_LONG  = 1'b1
  } wdt_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PS_W = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [PS_W-1:0] psc_q;

  assign tick_o = run_i && (&psc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (clr_i)  psc_q <= '0;
    else if (run_i)  psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SHORT_LIM = 3,
  parameter int LONG_LIM  = 7
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     clr_i,
  input  wdt_sel_e sel_i,
  output logic     fire_o
);
  localparam logic [CNT_W-1:0] SHORT_THR = CNT_W'(SHORT_LIM - 1);
  localparam logic [CNT_W-1:0] LONG_THR  = CNT_W'(LONG_LIM - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;

  assign thr    = (sel_i == SEL_LONG) ? LONG_THR : SHORT_THR;
  // fires on the tick that completes the period; >= covers a lowered threshold
  assign fire_o = tick_i && !clr_i && (cnt_q >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || fire_o)           cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic kill_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        left_q <= '0;
    else if (kill_i)    left_q <= '0;
    else if (fire_i)    left_q <= PW'(PULSE_LEN);
    else if (active_o)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int PS_W      = 13,
  parameter int CNT_W     = 4,
  parameter int SHORT_LIM = 3,
  parameter int LONG_LIM  = 7,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_en_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              wdt_rst_no
);
  wdt_sel_e sel_q, sel_eff;
  logic     clr_req, pulse_on, run, tick, fire, cnt_clr, psc_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= SEL_SHORT;
    else if (wr_en_i) sel_q <= wdt_sel_e'(wr_data_i[SEL_BIT]);
  end

  assign clr_req = wr_en_i && !wr_data_i[CLR_BIT];
  assign sel_eff = wr_en_i ? wdt_sel_e'(wr_data_i[SEL_BIT]) : sel_q;
  assign run     = wdt_en_i && !stop_i && !pulse_on;
  assign cnt_clr = clr_req || !wdt_en_i;
  assign psc_clr = cnt_clr || fire;

  wdt_prescaler #(.PS_W(PS_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (psc_clr),
    .tick_o (tick)
  );

  wdt_counter #(
    .CNT_W    (CNT_W),
    .SHORT_LIM(SHORT_LIM),
    .LONG_LIM (LONG_LIM)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (cnt_clr),
    .sel_i  (sel_eff),
    .fire_o (fire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .kill_i   (!wdt_en_i),
    .active_o (pulse_on)
  );

  assign wdt_rst_no = !pulse_on;

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[CLR_BIT] = 1'b1;
    rd_data_o[SEL_BIT] = sel_q;
  end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wdt_en_i,
  input logic       stop_i,
  input logic       wr_en_i,
  input logic [3:0] wr_data_i,
  input logic [3:0] rd_data_o,
  input logic       wdt_rst_no
);
  logic [7:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_run <= '0;
    else if (!wdt_rst_no) low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  p_pulse_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_rst_no |-> low_run < 8'(PULSE_LEN));

  p_pulse_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_no) |-> low_run == 8'(PULSE_LEN));

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[3] && wdt_rst_no) |=> wdt_rst_no);

  p_rd_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3:1] == 3'b100);

  p_rd_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[0] == $past(wr_data_i[0]));

  p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wdt_rst_no) |=> wdt_rst_no);

  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |=> wdt_rst_no);
endmodule

bind wdt_timer wdt_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wdt_en_i   (wdt_en_i),
  .stop_i     (stop_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .wdt_rst_no (wdt_rst_no)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PS_W  = 4;
  localparam int PER   = 1 << PS_W;
  localparam int SHORT = 3 * PER;
  localparam int LONG  = 7 * PER;
  localparam int PLEN  = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wdt_en_i = 1'b1;
  logic       stop_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic [3:0] rd_data_o;
  logic       wdt_rst_no;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_timer #(.PS_W(PS_W), .PULSE_LEN(PLEN)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdt_en_i(wdt_en_i), .stop_i(stop_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .wdt_rst_no(wdt_rst_no)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic wr(logic [3:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic edges_to_low(int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      step(1);
      if (!wdt_rst_no) begin n = i; break; end
    end
  endtask

  task automatic low_len(output int n);
    n = 1;
    while (!wdt_rst_no && n < 50) begin
      step(1);
      if (!wdt_rst_no) n++;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wdt_en_i = 1'b1; stop_i = 1'b0; wr_en_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out", int'(wdt_rst_no), 1);
    check("R1 rd", int'(rd_data_o), 4'b1000);
  endtask

  task automatic t_short();
    int n;
    do_reset();
    wr(4'b0000);
    edges_to_low(LONG + 20, n);
    check("R2 short timeout", n, SHORT);
    low_len(n);
    check("R4 pulse width", n, PLEN);
    edges_to_low(LONG + 20, n);
    check("R4 restart period", n, SHORT);
  endtask

  task automatic t_long();
    int n;
    do_reset();
    wr(4'b0001);
    check("R7 rd long", int'(rd_data_o), 4'b1001);
    edges_to_low(LONG + 20, n);
    check("R3 long timeout", n, LONG);
    low_len(n);
    check("R4 pulse width long", n, PLEN);
    edges_to_low(LONG + 20, n);
    check("R4 restart long", n, LONG);
  endtask

  task automatic t_clear_at_fire();
    int n;
    do_reset();
    wr(4'b0000);
    step(SHORT - 1);
    wr(4'b0000);  // lands on the edge the timeout was due
    check("R5 no pulse on clear edge", int'(wdt_rst_no), 1);
    edges_to_low(LONG + 20, n);
    check("R5 clear restarts", n, SHORT);
  endtask

  task automatic t_feed();
    int lows = 0;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      wr(4'b0000);
      for (int j = 0; j < SHORT - 8; j++) begin
        step(1);
        if (!wdt_rst_no) lows++;
      end
    end
    check("R5 periodic clear keeps high", lows, 0);
  endtask

  task automatic t_ignore();
    int n;
    do_reset();
    wr(4'b0000);
    step(19);
    wr(4'b1000);
    check("R6 rd after bit3=1", int'(rd_data_o), 4'b1000);
    edges_to_low(LONG + 20, n);
    check("R6 no clear", n, SHORT - 20);
  endtask

  task automatic t_stop();
    int n, lows = 0;
    do_reset();
    wr(4'b0000);
    step(10);
    stop_i = 1'b1;
    for (int j = 0; j < 100; j++) begin
      step(1);
      if (!wdt_rst_no) lows++;
    end
    check("R8 held in stop", lows, 0);
    stop_i = 1'b0;
    edges_to_low(LONG + 20, n);
    check("R8 resume", n, SHORT - 10);
  endtask

  task automatic t_disable();
    int n, lows = 0;
    do_reset();
    wdt_en_i = 1'b0;
    for (int j = 0; j < 200; j++) begin
      step(1);
      if (!wdt_rst_no) lows++;
    end
    check("R9 disabled high", lows, 0);
    wdt_en_i = 1'b1;
    edges_to_low(LONG + 20, n);
    check("R9 full period on enable", n, SHORT);
  endtask

  task automatic t_sel_switch();
    int n;
    do_reset();
    wr(4'b0001);
    step(5 * PER + 9);  // counter holds 5
    wr(4'b1000);
    check("R7 rd short", int'(rd_data_o), 4'b1000);
    edges_to_low(LONG + 20, n);
    check("R10 fire at next tick", n, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_long();
    t_clear_at_fire();
    t_feed();
    t_ignore();
    t_stop();
    t_disable();
    t_sel_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule